// File: doc/BRIEF.md
# Synchronous Rectifier Gate Sequencer

This block is the clocked decision core that sits behind a secondary-side synchronous rectifier. It owns two gate commands: the forward gate, which conducts while the primary delivers energy, and the catch gate, which carries the inductor current during the freewheel interval. Its inputs are the outputs of two sync comparators, one for each pulse polarity, a reverse-current comparator, an undervoltage detector and a few static configuration values. All of these are already synchronous to the block clock.

A negative sync edge turns the forward gate on. A positive sync edge hands conduction to the catch gate. Between pulses the gates keep their last commanded state. A watchdog turns both gates off when the pulse train stops or becomes malformed. The watchdog is only refreshed by a negative pulse that follows a positive one, so a train of pulses of a single polarity cannot keep the forward gate on for ever.

Once the catch gate has been on for a programmable blanking window, the reverse-current flag can switch it off. The catch gate then stays off until the next positive pulse. An undervoltage condition masks both gates at once.

Top module: `sr_gate_seq`

## Requirements
- R1: A rising edge on `neg_flag_i` alone sets the forward gate high and the catch gate low from the next clock edge on, unless the outputs are masked.
- R2: A rising edge on `pos_flag_i` alone sets the catch gate high and the forward gate low from the next clock edge on, unless the outputs are masked.
- R3: With no sync edge, no trip and no mask, both gates keep their previous values.
- R4: An accepted negative edge starts a restart pulse of `RST_LEN` cycles, during which the watchdog count is held at zero. After the pulse the watchdog counts cycles. Both gates are forced low from clock edge `RST_LEN + tmo_cycles_i` after the accepted edge onward (`tmo_cycles_i` >= 1).
- R5: A negative edge is accepted only if a positive edge occurred since the previous negative edge. A rejected negative edge does not restart the watchdog, so expiry keeps the timing of the last accepted edge.
- R6: After expiry, both gates stay low through rejected negative edges. A positive edge clears the expiry, and the catch gate goes high on that edge.
- R7: While `tmo_en_i` is 0, the watchdog never expires and its count is held cleared.
- R8: The reverse-current flag has no effect during the first `blank_cycles_i` clock edges after the positive edge that turns the catch gate on. At any later edge, a set flag turns the catch gate off. It stays off until the next positive edge.
- R9: While `uv_flag_i` is 1, both outputs are 0 in the same cycle. The internal gate state still follows the sync edges and appears once the flag clears.
- R10: The forward and catch outputs are never both 1.
- R11: After reset both gates are 0 and the first negative edge is accepted.
- R12: Rising edges on both sync flags in the same cycle are ignored.
- R13: Each sync flag acts only on its rising edge. A flag held high produces a single event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| neg_flag_i | input | 1 | Negative-pulse comparator flag, synchronous |
| pos_flag_i | input | 1 | Positive-pulse comparator flag, synchronous |
| rev_flag_i | input | 1 | Reverse-current comparator flag |
| uv_flag_i | input | 1 | Undervoltage flag, masks both gates |
| tmo_en_i | input | 1 | 1 enables the watchdog |
| tmo_cycles_i | input | TMO_W | Watchdog timeout in cycles after the restart pulse, at least 1 |
| blank_cycles_i | input | BLK_W | Reverse-current blanking window in cycles |
| fwd_gate_o | output | 1 | Forward gate command |
| catch_gate_o | output | 1 | Catch gate command |

## Verification
The assertions assume that the two sync flags never rise in the same cycle except where a conflicting event is being applied on purpose. They also assume that `tmo_cycles_i` is nonzero and that both configuration values stay constant while a timing window is being measured. The stimulus changes every input at the falling clock edge and changes configuration only between measured windows. The timeout sweep never programs a zero timeout. Two-edge conflicts appear only in the test that checks they are ignored.

// File: rtl/sr_gate_pkg.sv
package sr_gate_pkg;

   // Classified sync event, bit 0 = negative edge, bit 1 = positive edge
   typedef enum logic [1:0] {
      EV_NONE = 2'b00,
      EV_NEG  = 2'b01,
      EV_POS  = 2'b10,
      EV_BOTH = 2'b11
   } sync_ev_e;

   localparam int FLAG_NEG = 0;
   localparam int FLAG_POS = 1;
   localparam int N_FLAGS  = 2;

endpackage

// File: rtl/sr_rise_det.sv
module sr_rise_det #(
   parameter int N = 2
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] lvl_i,
   output logic [N-1:0] rise_o
);

   logic [N-1:0] prev_q;

   for (genvar g = 0; g < N; g++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) prev_q[g] <= 1'b0;
         else        prev_q[g] <= lvl_i[g];
      end
      assign rise_o[g] = lvl_i[g] & ~prev_q[g];

      // R13: a held level yields no second event
      p_single_evt_r13: assert property (@(posedge clk) disable iff (!rst_n)
         rise_o[g] && lvl_i[g] |=> !rise_o[g]);
   end

endmodule

// File: rtl/sr_watchdog.sv
module sr_watchdog #(
   parameter int TMO_W   = 12,
   parameter int RST_LEN = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             en_i,
   input  logic [TMO_W-1:0] tmo_i,
   input  logic             neg_i,
   input  logic             pos_i,
   output logic             expired_o
);

   localparam int RW = $clog2(RST_LEN + 1);

   logic             armed_q;
   logic [RW-1:0]    rst_left_q;
   logic [TMO_W-1:0] cnt_q;
   logic             tout_q;
   logic             restart;

   assign restart = neg_i & armed_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         armed_q    <= 1'b1;
         rst_left_q <= '0;
         cnt_q      <= '0;
         tout_q     <= 1'b0;
      end else begin
         if (pos_i)      armed_q <= 1'b1;
         else if (neg_i) armed_q <= 1'b0;

         if (!en_i) begin
            cnt_q      <= '0;
            tout_q     <= 1'b0;
            rst_left_q <= '0;
         end else if (restart) begin
            rst_left_q <= RW'(RST_LEN);
            cnt_q      <= '0;
            tout_q     <= 1'b0;
         end else if (pos_i && tout_q) begin
            cnt_q  <= '0;
            tout_q <= 1'b0;
         end else if (rst_left_q != '0) begin
            rst_left_q <= rst_left_q - RW'(1);
            cnt_q      <= '0;
         end else if (!tout_q) begin
            if (cnt_q == tmo_i - TMO_W'(1)) tout_q <= 1'b1;
            else                            cnt_q  <= cnt_q + TMO_W'(1);
         end
      end
   end

   assign expired_o = tout_q;

   // R5: an unpaired negative edge leaves the restart pulse idle
   p_reject_r5: assert property (@(posedge clk) disable iff (!rst_n)
      en_i && neg_i && !armed_q && rst_left_q == '0 |=> rst_left_q == '0);

   // R7: disabled watchdog never reports expiry
   p_disabled_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !en_i |=> !expired_o);

   // R4: no expiry while the restart pulse is running
   p_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      en_i && rst_left_q != '0 |=> !expired_o);

   // R6: expiry persists until a positive edge or accepted restart
   p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
      en_i && expired_o && !pos_i && !neg_i |=> expired_o);

endmodule

// File: rtl/sr_rev_blank.sv
module sr_rev_blank #(
   parameter int BLK_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             rise_i,
   input  logic             on_i,
   input  logic             rev_i,
   input  logic [BLK_W-1:0] blank_i,
   output logic             trip_o
);

   logic [BLK_W-1:0] bcnt_q;
   logic             open_w;

   assign open_w = (bcnt_q >= blank_i);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    bcnt_q <= '0;
      else if (rise_i)               bcnt_q <= '0;
      else if (on_i && !open_w)      bcnt_q <= bcnt_q + BLK_W'(1);
   end

   assign trip_o = on_i & ~rise_i & rev_i & open_w;

   // R8: the window restarts at every positive edge
   p_window_restart_r8: assert property (@(posedge clk) disable iff (!rst_n)
      rise_i |=> bcnt_q == '0);

endmodule

// File: rtl/sr_gate_seq.sv
module sr_gate_seq
   import sr_gate_pkg::*;
#(
   parameter int TMO_W   = 12,
   parameter int BLK_W   = 6,
   parameter int RST_LEN = 10
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             neg_flag_i,
   input  logic             pos_flag_i,
   input  logic             rev_flag_i,
   input  logic             uv_flag_i,
   input  logic             tmo_en_i,
   input  logic [TMO_W-1:0] tmo_cycles_i,
   input  logic [BLK_W-1:0] blank_cycles_i,
   output logic             fwd_gate_o,
   output logic             catch_gate_o
);

   if (TMO_W < 2) begin : g_bad_tmo
      $error("sr_gate_seq: TMO_W must be at least 2");
   end
   if (BLK_W < 1) begin : g_bad_blk
      $error("sr_gate_seq: BLK_W must be at least 1");
   end
   if (RST_LEN < 1) begin : g_bad_rst
      $error("sr_gate_seq: RST_LEN must be at least 1");
   end

   logic [N_FLAGS-1:0] lvl, rise;
   sync_ev_e           ev;
   logic               neg_ok, pos_ok;
   logic               expired, trip, masked;
   logic               fwd_q, catch_q;

   assign lvl[FLAG_NEG] = neg_flag_i;
   assign lvl[FLAG_POS] = pos_flag_i;

   sr_rise_det #(.N(N_FLAGS)) i_rise (
      .clk    (clk),
      .rst_n  (rst_n),
      .lvl_i  (lvl),
      .rise_o (rise)
   );

   assign ev     = sync_ev_e'(rise);
   assign neg_ok = (ev == EV_NEG);
   assign pos_ok = (ev == EV_POS);

   sr_watchdog #(.TMO_W(TMO_W), .RST_LEN(RST_LEN)) i_wdog (
      .clk       (clk),
      .rst_n     (rst_n),
      .en_i      (tmo_en_i),
      .tmo_i     (tmo_cycles_i),
      .neg_i     (neg_ok),
      .pos_i     (pos_ok),
      .expired_o (expired)
   );

   sr_rev_blank #(.BLK_W(BLK_W)) i_blank (
      .clk     (clk),
      .rst_n   (rst_n),
      .rise_i  (pos_ok),
      .on_i    (catch_q),
      .rev_i   (rev_flag_i),
      .blank_i (blank_cycles_i),
      .trip_o  (trip)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fwd_q   <= 1'b0;
         catch_q <= 1'b0;
      end else begin
         unique case (ev)
            EV_NEG: begin
               fwd_q   <= 1'b1;
               catch_q <= 1'b0;
            end
            EV_POS: begin
               fwd_q   <= 1'b0;
               catch_q <= 1'b1;
            end
            default: begin
               if (trip) catch_q <= 1'b0;
            end
         endcase
      end
   end

   assign masked       = uv_flag_i | expired;
   assign fwd_gate_o   = fwd_q   & ~masked;
   assign catch_gate_o = catch_q & ~masked;

   // R10: gates mutually exclusive
   p_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
      !(fwd_gate_o && catch_gate_o));

   // R9: undervoltage masks both outputs
   p_uv_mask_r9: assert property (@(posedge clk) disable iff (!rst_n)
      uv_flag_i |-> !fwd_gate_o && !catch_gate_o);

   // R1: lone negative edge hands conduction to the forward gate
   p_neg_map_r1: assert property (@(posedge clk) disable iff (!rst_n)
      neg_flag_i && !$past(neg_flag_i) && !(pos_flag_i && !$past(pos_flag_i))
      |=> fwd_q && !catch_q);

   // R2: lone positive edge hands conduction to the catch gate
   p_pos_map_r2: assert property (@(posedge clk) disable iff (!rst_n)
      pos_flag_i && !$past(pos_flag_i) && !(neg_flag_i && !$past(neg_flag_i))
      |=> catch_q && !fwd_q);

   // R8: once off, the catch gate returns only on a positive edge
   p_catch_relight_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !catch_q && !pos_ok |=> !catch_q);

   // R12: simultaneous edges leave the gate state untouched
   p_both_ignored_r12: assert property (@(posedge clk) disable iff (!rst_n)
      ev == EV_BOTH && !trip |=> $stable(fwd_q) && $stable(catch_q));

endmodule

// File: tb/test_sr_gate_seq.sv
module test_sr_gate_seq;

   localparam int TMO_W   = 8;
   localparam int BLK_W   = 4;
   localparam int RST_LEN = 3;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             neg_flag = 1'b0, pos_flag = 1'b0, rev_flag = 1'b0, uv_flag = 1'b0;
   logic             tmo_en = 1'b0;
   logic [TMO_W-1:0] tmo_cycles = 8'd4;
   logic [BLK_W-1:0] blank_cycles = 4'd2;
   logic             fwd, catchg;

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   sr_gate_seq #(.TMO_W(TMO_W), .BLK_W(BLK_W), .RST_LEN(RST_LEN)) i_sr_gate_seq (
      .clk            (clk),
      .rst_n          (rst_n),
      .neg_flag_i     (neg_flag),
      .pos_flag_i     (pos_flag),
      .rev_flag_i     (rev_flag),
      .uv_flag_i      (uv_flag),
      .tmo_en_i       (tmo_en),
      .tmo_cycles_i   (tmo_cycles),
      .blank_cycles_i (blank_cycles),
      .fwd_gate_o     (fwd),
      .catch_gate_o   (catchg)
   );

   task automatic chk(input string req, input logic got, input logic exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0b expected %0b at cycle %0d", req, got, exp, cyc);
      end
   endtask

   task automatic chk_gates(input string req, input logic ef, input logic ec);
      chk({req, " fwd"}, fwd, ef);
      chk({req, " catch"}, catchg, ec);
      chk("R10 exclusive", fwd & catchg, 1'b0);
   endtask

   // flags raised at one falling edge, dropped at the next; returns right after the event edge
   task automatic fire(input logic n, input logic p);
      @(negedge clk);
      neg_flag = n;
      pos_flag = p;
      @(negedge clk);
      neg_flag = 1'b0;
      pos_flag = 1'b0;
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 100000 && !done) begin
         done = 1'b1;
         fails++;
         checks++;
         $display("FAIL watchdog: got hung expected completion");
         $display("%0d/%0d checks passed", checks - fails, checks);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      chk_gates("R11 reset", 1'b0, 1'b0);
      rst_n = 1'b1;
      tmo_en = 1'b1;
      tmo_cycles = 8'd5;
      @(negedge clk);
      chk_gates("R11 after reset", 1'b0, 1'b0);

      // R11/R4: first negative edge after reset is accepted
      fire(1'b1, 1'b0);
      for (int n = 0; n < RST_LEN + 5 + 3; n++) begin
         chk_gates("R11 R4 first neg", (n < RST_LEN + 5) ? 1'b1 : 1'b0, 1'b0);
         @(negedge clk);
      end

      // R4 sweep of timeout values
      for (int t = 1; t <= 8; t++) begin
         tmo_cycles = TMO_W'(t);
         fire(1'b0, 1'b1);
         chk_gates("R6 R2 resume", 1'b0, 1'b1);
         fire(1'b1, 1'b0);
         for (int n = 0; n < RST_LEN + t + 3; n++) begin
            chk_gates("R4 timeout", (n < RST_LEN + t) ? 1'b1 : 1'b0, 1'b0);
            @(negedge clk);
         end
      end

      // R6: rejected negative edge while expired keeps gates low
      fire(1'b1, 1'b0);
      repeat (2) @(negedge clk);
      chk_gates("R6 low after bad neg", 1'b0, 1'b0);
      fire(1'b0, 1'b1);
      chk_gates("R6 positive resumes", 1'b0, 1'b1);

      // R5: second negative edge does not restart
      tmo_cycles = 8'd8;
      fire(1'b1, 1'b0);
      for (int n = 0; n < RST_LEN + 8 + 4; n++) begin
         chk_gates("R5 no restart", (n < RST_LEN + 8) ? 1'b1 : 1'b0, 1'b0);
         if (n == 3) neg_flag = 1'b1;
         @(negedge clk);
         if (n == 3) neg_flag = 1'b0;
      end

      // R7: disabled watchdog
      tmo_en = 1'b0;
      tmo_cycles = 8'd2;
      fire(1'b0, 1'b1);
      fire(1'b1, 1'b0);
      repeat (RST_LEN + 10) @(negedge clk);
      chk_gates("R7 R3 no expiry", 1'b1, 1'b0);

      // R12: simultaneous edges ignored
      fire(1'b1, 1'b1);
      chk_gates("R12 both ignored", 1'b1, 1'b0);
      @(negedge clk);
      chk_gates("R12 R3 hold", 1'b1, 1'b0);

      // R13: held negative flag acts once
      fire(1'b0, 1'b1);
      @(negedge clk);
      neg_flag = 1'b1;
      @(negedge clk);
      chk_gates("R1 neg edge", 1'b1, 1'b0);
      pos_flag = 1'b1;
      @(negedge clk);
      pos_flag = 1'b0;
      chk_gates("R2 pos while neg held", 1'b0, 1'b1);
      repeat (3) @(negedge clk);
      chk_gates("R13 held flag no repeat", 1'b0, 1'b1);
      neg_flag = 1'b0;
      @(negedge clk);

      // R8: blanking sweep with reverse flag held high
      rev_flag = 1'b1;
      for (int b = 0; b <= 6; b++) begin
         blank_cycles = BLK_W'(b);
         fire(1'b1, 1'b0);
         fire(1'b0, 1'b1);
         for (int n = 0; n < b + 4; n++) begin
            chk_gates("R8 blanking", 1'b0, (n <= b) ? 1'b1 : 1'b0);
            @(negedge clk);
         end
      end
      rev_flag = 1'b0;

      // R8: late trip latches until next positive edge
      blank_cycles = 4'd3;
      fire(1'b0, 1'b1);
      repeat (8) @(negedge clk);
      chk_gates("R8 no trip without flag", 1'b0, 1'b1);
      rev_flag = 1'b1;
      @(negedge clk);
      chk_gates("R8 late trip", 1'b0, 1'b0);
      rev_flag = 1'b0;
      repeat (3) @(negedge clk);
      chk_gates("R8 trip latched", 1'b0, 1'b0);
      fire(1'b0, 1'b1);
      chk_gates("R8 relit by positive", 1'b0, 1'b1);

      // R9: undervoltage mask
      fire(1'b1, 1'b0);
      uv_flag = 1'b1;
      #1;
      chk_gates("R9 uv immediate", 1'b0, 1'b0);
      fire(1'b0, 1'b1);
      chk_gates("R9 uv during edge", 1'b0, 1'b0);
      uv_flag = 1'b0;
      #1;
      chk_gates("R9 state kept", 1'b0, 1'b1);

      done = 1'b1;
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

endmodule